// File: doc/BRIEF.md
# Single-Bin Streaming DFT Core

This block evaluates one output frequency of a discrete Fourier transform whose length is any value from 2 to 1023; the length need not be a power of two. A run starts with a one-cycle `enable` pulse. Complex samples then arrive at most one per clock, as a 32-bit signed real word and a 32-bit signed imaginary word. The core pairs each accepted sample with the twiddle factor for angle 2*pi*n*k/N. It multiplies the two in signed fixed point and adds the result into separate real and imaginary sums.

The twiddle address is a running remainder. Each accepted sample adds k to it, and the length is subtracted whenever the total reaches the length. This removes any need for a multiplier or divider in the address path. The cosine and sine table holds Q1.30 values (2^30 represents 1.0) for the table length set by the `TABLE_LEN` parameter. The `lenIn` input must equal that parameter, and `binIdx` must be below it. One select input picks the forward or the inverse kernel. When the producer raises `empty`, the core raises `ready`. It raises `done` once the two-stage multiply/accumulate pipeline has drained, and from then on the result ports hold the final sums.

Top module: `dft_bin_top`

## Requirements
- R1: After reset, `ready` and `done` are 0 and both result ports read 0.
- R2: The clock edge that samples `enable` high zeroes both sums, the sample index and the twiddle address, and clears `ready` and `done`. A sample presented on that edge is not taken. Results of a new run do not depend on any earlier run.
- R3: A sample is taken only on an edge where the core is running, `sampleValid` is 1 and `empty` is 0. Data presented with `sampleValid` at 0, or after the run has ended, leaves the sums unchanged.
- R4: Sample n (counting from 0 after `enable`) is weighted by the twiddle for angle index (n*k) mod N. This holds for lengths that are not powers of two, and for bins whose steps wrap past N.
- R5: With `inverseSel` = 0 (forward), each sample adds Xr*cos + Xi*sin to the real sum and Xi*cos - Xr*sin to the imaginary sum. Each term is taken as floor(term/2^30), and the tolerance is a few LSB per sample.
- R6: With `inverseSel` = 1 (inverse), both sine terms change sign: the real sum gains Xr*cos - Xi*sin and the imaginary sum gains Xi*cos + Xr*sin.
- R7: `ready` rises after the first edge that samples `empty` high while running. While streaming it stays 0, and once high it stays high until the next `enable`.
- R8: `done` rises only after both pipeline stages are empty. When `empty` follows directly after the last sample, `done` rises two edges after `ready`. It implies `ready`, and while it is high the result ports do not change.
- R9: With k = 0 every twiddle is exactly cos = 2^30 and sin = 0. The real sum is then exactly the sum of the real inputs, and the imaginary sum is exactly the sum of the imaginary inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | One-cycle pulse that clears the core and starts a run |
| inverseSel | input | 1 | 0 = forward kernel (exp -j), 1 = inverse kernel (exp +j) |
| sampleValid | input | 1 | Sample words are valid this cycle |
| empty | input | 1 | Producer has no more samples; ends the stream |
| binIdx | input | 10 | Output bin k, below the length |
| lenIn | input | 10 | Transform length N; equals TABLE_LEN |
| xReIn | input | 32 | Sample real part, signed |
| xImIn | input | 32 | Sample imaginary part, signed |
| xReOut | output | 32 | Real sum, signed |
| xImOut | output | 32 | Imaginary sum, signed |
| ready | output | 1 | Input stream finished |
| done | output | 1 | Pipeline drained; result final |

## Verification
A twiddle address that drifts off (n*k) mod N shows up as a bin value far outside the tolerance at `done`. The error appears only after the stream ends, so every run is compared against a floating-point model with bins chosen to make the address wrap. A stale pipeline stage or a sum left over from an earlier run shows at the result ports on the edge right after `enable`, where both must read zero. A drain counter that is off by one changes the cycle on which `done` rises, and that cycle is checked exactly against `ready`.

// File: rtl/dft_bin_pkg.sv
`timescale 1ns/1ps
package dft_bin_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 10;
  localparam int TW_FRAC = 30;
  localparam int PROD_W  = 2 * DATA_W;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_FIN} dft_state_t;

  typedef struct packed {
    logic clear;
    logic accept;
  } dft_ctrl_t;
endpackage

// File: rtl/dft_twiddle_rom.sv
`timescale 1ns/1ps
module dft_twiddle_rom
  import dft_bin_pkg::*;
#(
  parameter int TABLE_LEN = 12
) (
  input  logic        [ADDR_W-1:0] addr,
  output logic signed [DATA_W-1:0] cosVal,
  output logic signed [DATA_W-1:0] sinVal
);
  localparam int TAB_IDX_W = (TABLE_LEN > 1) ? $clog2(TABLE_LEN) : 1;
  localparam int TAB_SIZE  = 1 << TAB_IDX_W;
  localparam real TWO_PI   = 6.283185307179586;
  localparam real ONE_Q    = 1073741824.0;

  logic signed [DATA_W-1:0] cosTab [TAB_SIZE];
  logic signed [DATA_W-1:0] sinTab [TAB_SIZE];
  logic [TAB_IDX_W-1:0] tabIdx;

  // Constant ROM contents computed once for the configured length
  initial begin
    for (int i = 0; i < TAB_SIZE; i++) begin
      real ang;
      if (i < TABLE_LEN) begin
        ang = TWO_PI * real'(i) / real'(TABLE_LEN);
        cosTab[i] = $rtoi($cos(ang) * ONE_Q);
        sinTab[i] = $rtoi($sin(ang) * ONE_Q);
      end else begin
        cosTab[i] = '0;
        sinTab[i] = '0;
      end
    end
  end

  assign tabIdx = TAB_IDX_W'(addr);
  assign cosVal = cosTab[tabIdx];
  assign sinVal = sinTab[tabIdx];
endmodule

// File: rtl/dft_bin_ctrl.sv
`timescale 1ns/1ps
module dft_bin_ctrl
  import dft_bin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      sampleValid,
  input  logic      empty,
  input  logic      busy,
  output dft_ctrl_t ctrlOut,
  output logic      ready,
  output logic      done
);
  dft_state_t state;

  always_comb begin
    ctrlOut.clear  = enable;
    ctrlOut.accept = (state == ST_RUN) && !enable && sampleValid && !empty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ready <= 1'b0;
      done  <= 1'b0;
    end else if (enable) begin
      state <= ST_RUN;
      ready <= 1'b0;
      done  <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: if (empty) begin
          state <= ST_DRAIN;
          ready <= 1'b1;
        end
        ST_DRAIN: if (!busy) begin
          state <= ST_FIN;
          done  <= 1'b1;
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/dft_bin_datapath.sv
`timescale 1ns/1ps
module dft_bin_datapath
  import dft_bin_pkg::*;
#(
  parameter int TABLE_LEN = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dft_ctrl_t                ctrlIn,
  input  logic                     inverseSel,
  input  logic        [ADDR_W-1:0] binIdx,
  input  logic        [ADDR_W-1:0] lenIn,
  input  logic signed [DATA_W-1:0] xReIn,
  input  logic signed [DATA_W-1:0] xImIn,
  output logic signed [DATA_W-1:0] accRe,
  output logic signed [DATA_W-1:0] accIm,
  output logic                     busy
);
  // Theta unit: running (n*k) mod N
  logic [ADDR_W-1:0] theta, stepVal, thetaNext;
  logic [ADDR_W:0]   thetaSum;

  assign stepVal   = (binIdx >= lenIn) ? binIdx - lenIn : binIdx;
  assign thetaSum  = {1'b0, theta} + {1'b0, stepVal};
  assign thetaNext = (thetaSum >= {1'b0, lenIn}) ? ADDR_W'(thetaSum - {1'b0, lenIn})
                                                 : ADDR_W'(thetaSum);

  // Stage 0: captured sample and its twiddle address
  logic                     s0Valid;
  logic        [ADDR_W-1:0] s0Addr;
  logic signed [DATA_W-1:0] s0Re, s0Im;
  // Stage 1: rounded product terms
  logic                     s1Valid;
  logic signed [DATA_W-1:0] s1Re, s1Im;

  logic signed [DATA_W-1:0] cosVal, sinVal;

  dft_twiddle_rom #(.TABLE_LEN(TABLE_LEN)) u_rom (
    .addr  (s0Addr),
    .cosVal(cosVal),
    .sinVal(sinVal)
  );

  // Complex multiply with direction-dependent sine sign
  logic signed [PROD_W-1:0] xrCos, xiSin, xiCos, xrSin, reSum, imSum;
  logic signed [DATA_W-1:0] reTerm, imTerm;

  assign xrCos = PROD_W'(s0Re) * PROD_W'(cosVal);
  assign xiSin = PROD_W'(s0Im) * PROD_W'(sinVal);
  assign xiCos = PROD_W'(s0Im) * PROD_W'(cosVal);
  assign xrSin = PROD_W'(s0Re) * PROD_W'(sinVal);

  always_comb begin
    if (inverseSel) begin
      reSum = xrCos - xiSin;
      imSum = xiCos + xrSin;
    end else begin
      reSum = xrCos + xiSin;
      imSum = xiCos - xrSin;
    end
    reTerm = DATA_W'(reSum >>> TW_FRAC);
    imTerm = DATA_W'(imSum >>> TW_FRAC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      theta   <= '0;
      s0Valid <= 1'b0;
      s0Addr  <= '0;
      s0Re    <= '0;
      s0Im    <= '0;
      s1Valid <= 1'b0;
      s1Re    <= '0;
      s1Im    <= '0;
      accRe   <= '0;
      accIm   <= '0;
    end else if (ctrlIn.clear) begin
      theta   <= '0;
      s0Valid <= 1'b0;
      s1Valid <= 1'b0;
      accRe   <= '0;
      accIm   <= '0;
    end else begin
      s0Valid <= ctrlIn.accept;
      if (ctrlIn.accept) begin
        theta  <= thetaNext;
        s0Addr <= theta;
        s0Re   <= xReIn;
        s0Im   <= xImIn;
      end
      s1Valid <= s0Valid;
      if (s0Valid) begin
        s1Re <= reTerm;
        s1Im <= imTerm;
      end
      if (s1Valid) begin
        accRe <= accRe + s1Re;
        accIm <= accIm + s1Im;
      end
    end
  end

  assign busy = s0Valid | s1Valid;
endmodule

// File: rtl/dft_bin_top.sv
`timescale 1ns/1ps
module dft_bin_top
  import dft_bin_pkg::*;
#(
  parameter int TABLE_LEN = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic                     inverseSel,
  input  logic                     sampleValid,
  input  logic                     empty,
  input  logic        [ADDR_W-1:0] binIdx,
  input  logic        [ADDR_W-1:0] lenIn,
  input  logic signed [DATA_W-1:0] xReIn,
  input  logic signed [DATA_W-1:0] xImIn,
  output logic signed [DATA_W-1:0] xReOut,
  output logic signed [DATA_W-1:0] xImOut,
  output logic                     ready,
  output logic                     done
);
  dft_ctrl_t ctrlBus;
  logic      pipeBusy;

  dft_bin_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sampleValid(sampleValid),
    .empty      (empty),
    .busy       (pipeBusy),
    .ctrlOut    (ctrlBus),
    .ready      (ready),
    .done       (done)
  );

  dft_bin_datapath #(.TABLE_LEN(TABLE_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlIn    (ctrlBus),
    .inverseSel(inverseSel),
    .binIdx    (binIdx),
    .lenIn     (lenIn),
    .xReIn     (xReIn),
    .xImIn     (xImIn),
    .accRe     (xReOut),
    .accIm     (xImOut),
    .busy      (pipeBusy)
  );
endmodule

// File: rtl/dft_bin_checker.sv
`timescale 1ns/1ps
module dft_bin_checker (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        ready,
  input logic        done,
  input logic [31:0] xReOut,
  input logic [31:0] xImOut
);
  AST_ENABLE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> (!ready && !done)); // R2

  AST_ENABLE_ZEROES_SUMS: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> (xReOut == 32'd0 && xImOut == 32'd0)); // R2

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !enable) |=> ready); // R7

  AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !enable) |=> done); // R8

  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (done && !enable) |=> ($stable(xReOut) && $stable(xImOut))); // R8
endmodule

bind dft_bin_top dft_bin_checker u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .enable(enable),
  .ready (ready),
  .done  (done),
  .xReOut(xReOut),
  .xImOut(xImOut)
);

// File: tb/dft_bin_top_bench.sv
`timescale 1ns/1ps
module dft_bin_top_bench;
  localparam int  NLEN   = 12;
  localparam int  TOL    = 16;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, inverseSel = 1'b0, sampleValid = 1'b0, empty = 1'b0;
  logic [9:0] binIdx = '0, lenIn = 10'(NLEN);
  logic signed [31:0] xReIn = '0, xImIn = '0;
  logic signed [31:0] xReOut, xImOut;
  logic ready, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  dft_bin_top #(.TABLE_LEN(NLEN)) u_dft_bin_top (
    .clk(clk), .rstN(rstN), .enable(enable), .inverseSel(inverseSel),
    .sampleValid(sampleValid), .empty(empty), .binIdx(binIdx), .lenIn(lenIn),
    .xReIn(xReIn), .xImIn(xImIn), .xReOut(xReOut), .xImOut(xImOut),
    .ready(ready), .done(done)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int nextVal();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 12) - (1 << 19);
  endfunction

  // One full run; gaps insert invalid cycles carrying junk data.
  task automatic runXform(input int k, input bit inv, input int nSamp, input bit gaps,
                          input bit exact, input string req);
    real expRe = 0.0, expIm = 0.0;
    longint sumRe = 0, sumIm = 0;
    @(negedge clk);
    enable = 1'b1; empty = 1'b0; binIdx = 10'(k); inverseSel = inv;
    sampleValid = 1'b1; xReIn = 32'sd999; xImIn = 32'sd999;
    @(posedge clk); #1;
    check("R2 sums zero after enable", xReOut == 0 && xImOut == 0, xReOut, 0);
    check("R2 flags clear after enable", !ready && !done, {ready, done}, 0);
    @(negedge clk); enable = 1'b0; sampleValid = 1'b0;
    for (int n = 0; n < nSamp; n++) begin
      int xr, xi, a;
      real ang, c, s;
      if (gaps && (n % 3 == 1)) begin
        sampleValid = 1'b0; xReIn = 32'sd77777; xImIn = -32'sd55555;
        @(posedge clk); #1;
        check("R7 flags low in gap", !ready && !done, {ready, done}, 0);
        @(negedge clk);
      end
      xr = nextVal(); xi = nextVal();
      sampleValid = 1'b1; xReIn = xr; xImIn = xi;
      a = (n * k) % NLEN;
      ang = TWO_PI * real'(a) / real'(NLEN);
      c = $cos(ang); s = $sin(ang);
      if (inv) s = -s;
      expRe += real'(xr) * c + real'(xi) * s;
      expIm += real'(xi) * c - real'(xr) * s;
      sumRe += xr; sumIm += xi;
      @(posedge clk); #1;
      check("R7 flags low while streaming", !ready && !done, {ready, done}, 0);
      @(negedge clk);
    end
    sampleValid = 1'b0; empty = 1'b1;
    @(posedge clk); #1;
    check("R7 ready after empty", ready && !done, {ready, done}, 2);
    @(posedge clk); #1;
    check("R8 done not yet", ready && !done, {ready, done}, 2);
    @(posedge clk); #1;
    check("R8 done after drain", ready && done, {ready, done}, 3);
    if (exact) begin
      check({req, " real exact"}, longint'(xReOut) == sumRe, xReOut, sumRe);
      check({req, " imag exact"}, longint'(xImOut) == sumIm, xImOut, sumIm);
    end else begin
      longint eRe = longint'($rtoi(expRe));
      longint eIm = longint'($rtoi(expIm));
      longint dRe = longint'(xReOut) - eRe;
      longint dIm = longint'(xImOut) - eIm;
      check({req, " real"}, dRe <= TOL && dRe >= -TOL, xReOut, eRe);
      check({req, " imag"}, dIm <= TOL && dIm >= -TOL, xImOut, eIm);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 200000) begin
        check("watchdog", 1'b0, cycles, 0);
        finishRun();
      end
    end
  end

  initial begin
    logic signed [31:0] holdRe, holdIm;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", !ready && !done, {ready, done}, 0);
    check("R1 reset sums", xReOut == 0 && xImOut == 0, xReOut, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 idle after reset", !ready && !done && xReOut == 0, {ready, done}, 0);

    runXform(1, 1'b0, NLEN, 1'b0, 1'b0, "R5 forward k=1");
    runXform(5, 1'b0, NLEN, 1'b1, 1'b0, "R4 R3 forward k=5 gaps");
    runXform(3, 1'b1, NLEN, 1'b0, 1'b0, "R6 inverse k=3");
    runXform(11, 1'b1, NLEN, 1'b1, 1'b0, "R6 R4 inverse k=11");
    runXform(0, 1'b0, NLEN, 1'b1, 1'b1, "R9 bin zero");

    // R3: junk with valid high after the run has ended is ignored
    holdRe = xReOut; holdIm = xImOut;
    @(negedge clk); empty = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sampleValid = 1'b1; xReIn = 32'sd400000 + i; xImIn = -32'sd300000;
      @(posedge clk); #1;
      check("R3 no intake after end", xReOut == holdRe && xImOut == holdIm, xReOut, holdRe);
      check("R8 done holds", done && ready, {ready, done}, 3);
      @(negedge clk);
    end
    sampleValid = 1'b0;

    // R2: restart directly after a nonzero result
    runXform(7, 1'b0, NLEN, 1'b1, 1'b0, "R2 R4 restart k=7");
    runXform(2, 1'b0, 5, 1'b0, 1'b0, "R4 partial stream k=2");

    finishRun();
  end
endmodule